// File: doc/BRIEF.md
# Serial Register Write Port with Staged Commit

This block is a write-only serial slave for a chip's configuration registers. It takes three wires: an active-low load strobe, a serial clock and serial data. All three are sampled in the system clock domain. While the strobe is low, each frame carries an 8-bit address and then a 24-bit data word, and both fields are shifted in least significant bit first. If the strobe stays low after a frame, every further 24-bit word goes to the next address up. The address wraps from 0xFF to 0x00.

Each complete word lands in a shadow register. A word that is cut short by the strobe rising is dropped. Shadow values reach the active registers, which drive the rest of the chip, in one of two ways, chosen per register by a parameter mask.

- **Load-class registers** are copied when the strobe rises.
- **Sync-class registers** are copied on a chosen falling edge of horizontal sync after a falling edge of vertical sync.

Two load-class controls steer the sync commit. A hold bit blocks it, and a line number delays it to a later horizontal-sync edge within the field.

Top module: `sreg_write_port`

## Requirements
- R1: After reset every active register reads 0.
- R2: A frame is 8 address bits followed by 24 data bits, both least significant bit first, sampled on serial clock rises while the strobe is low. A load-class register (addresses 0 to 3) shows the written word once the strobe rises.
- R3: A load-class register keeps its old active value until the strobe rises, and changes at no other time.
- R4: A data word with fewer than 24 bits before the strobe rises is discarded, and the target register keeps its value.
- R5: With the strobe held low, each further 24-bit word is written to the previous address plus one.
- R6: Auto-increment wraps from address 0xFF to 0x00. Words sent to addresses with no register (16 and above) change nothing.
- R7: Register i keeps only its low W bits, where W is 8, 12, 16 or 24 for i mod 4 equal to 0, 1, 2 or 3. The upper data bits are ignored.
- R8: A sync-class register (addresses 4 to 15) does not change on the strobe rise. With line number 0, it takes its shadow value on the first horizontal-sync falling edge after a vertical-sync falling edge, and at no other time.
- R9: The line number in register 1, bits 11:0, delays the sync commit to horizontal-sync fall number N, counting from 0, after the vertical-sync fall.
- R10: While bit 0 of register 0 is 1, the sync commit is suppressed and sync-class registers keep their values.
- R11: A strobe rise clears the bit counter, and serial clocks seen while the strobe is high are ignored, so the next frame starts with an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_load_n | input | 1 | Active-low frame strobe |
| ser_clk | input | 1 | Serial bit clock, sampled by clk |
| ser_data | input | 1 | Serial data, taken on ser_clk rise |
| vsync | input | 1 | Vertical sync; a falling edge arms the commit |
| hsync | input | 1 | Horizontal sync; falling edges are counted |
| act_flat | output | NREG*24 | Active registers; register i is at bits [24*i +: 24] |

## Verification
The hardest case to reach is a sync commit that must land on one particular horizontal-sync edge while load-class state governs it. To reach it, the bench first programs the line number and the hold bit through ordinary strobe-terminated frames. It then writes a sync-class register and produces a vertical-sync fall followed by a counted series of horizontal-sync falls. It reads the register after every edge, so an early or late commit shows up. Wrap-around is reached by starting an auto-increment run at address 0xFF. A cut-short word is followed at once by a full frame, which shows that the bit counter was cleared.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int DW = 24;
  localparam int AW = 8;

  function automatic int reg_width(int idx);
    case (idx % 4)
      0:       return 8;
      1:       return 12;
      2:       return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [DW-1:0] width_mask(int idx);
    return {DW{1'b1}} >> (DW - reg_width(idx));
  endfunction
endpackage

// File: rtl/sreg_deframer.sv
module sreg_deframer
  import sreg_pkg::*;
#(
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          sclk,
  input  logic          sdata,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          load_rise,
  output logic          load_idle,
  output logic [CW-1:0] bit_cnt,
  output logic          addr_phase
);
  logic ld_meta, ld_sync, ld_prev;
  logic ck_meta, ck_sync, ck_prev;
  logic sd_meta, sd_sync;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_d;
  logic          aph_d;
  logic          wr_en_d;
  logic [AW-1:0] wr_addr_d;
  logic [DW-1:0] wr_data_d;
  logic          sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_meta <= 1'b1; ld_sync <= 1'b1; ld_prev <= 1'b1;
      ck_meta <= 1'b0; ck_sync <= 1'b0; ck_prev <= 1'b0;
      sd_meta <= 1'b0; sd_sync <= 1'b0;
    end else begin
      ld_meta <= load_n; ld_sync <= ld_meta; ld_prev <= ld_sync;
      ck_meta <= sclk;   ck_sync <= ck_meta; ck_prev <= ck_sync;
      sd_meta <= sdata;  sd_sync <= sd_meta;
    end
  end

  assign sck_rise  = ck_sync & ~ck_prev;
  assign load_rise = ld_sync & ~ld_prev;
  assign load_idle = ld_sync;

  always_comb begin
    sh_d      = sh_q;
    addr_d    = addr_q;
    cnt_d     = bit_cnt;
    aph_d     = addr_phase;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr;
    wr_data_d = wr_data;
    if (ld_sync) begin
      cnt_d = '0;
      aph_d = 1'b1;
    end else if (sck_rise) begin
      sh_d = {sd_sync, sh_q[DW-1:1]};
      if (addr_phase) begin
        if (bit_cnt == CW'(AW-1)) begin
          addr_d = sh_d[DW-1 -: AW];
          aph_d  = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = bit_cnt + 1'b1;
        end
      end else if (bit_cnt == CW'(DW-1)) begin
        wr_en_d   = 1'b1;
        wr_addr_d = addr_q;
        wr_data_d = sh_d;
        addr_d    = addr_q + 1'b1;
        cnt_d     = '0;
      end else begin
        cnt_d = bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      addr_q     <= '0;
      bit_cnt    <= '0;
      addr_phase <= 1'b1;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      sh_q       <= sh_d;
      addr_q     <= addr_d;
      bit_cnt    <= cnt_d;
      addr_phase <= aph_d;
      wr_en      <= wr_en_d;
      wr_addr    <= wr_addr_d;
      wr_data    <= wr_data_d;
    end
  end
endmodule

// File: rtl/sreg_line_timer.sv
module sreg_line_timer #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic          hsync,
  input  logic [LW-1:0] upd_line,
  output logic          commit
);
  logic vs_meta, vs_sync, vs_prev;
  logic hs_meta, hs_sync, hs_prev;
  logic vs_fall, hs_fall;
  logic armed_q, armed_d;
  logic [LW-1:0] line_q, line_d;
  logic commit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_meta <= 1'b1; vs_sync <= 1'b1; vs_prev <= 1'b1;
      hs_meta <= 1'b1; hs_sync <= 1'b1; hs_prev <= 1'b1;
    end else begin
      vs_meta <= vsync; vs_sync <= vs_meta; vs_prev <= vs_sync;
      hs_meta <= hsync; hs_sync <= hs_meta; hs_prev <= hs_sync;
    end
  end

  assign vs_fall = vs_prev & ~vs_sync;
  assign hs_fall = hs_prev & ~hs_sync;

  always_comb begin
    armed_d  = armed_q;
    line_d   = line_q;
    commit_d = 1'b0;
    if (vs_fall) begin
      armed_d = 1'b1;
      line_d  = '0;
    end else if (hs_fall && armed_q) begin
      if (line_q == upd_line) begin
        commit_d = 1'b1;
        armed_d  = 1'b0;
      end else begin
        line_d = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      line_q  <= '0;
      commit  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      line_q  <= line_d;
      commit  <= commit_d;
    end
  end
endmodule

// File: rtl/sreg_write_port.sv
module sreg_write_port
  import sreg_pkg::*;
#(
  parameter int          NREG      = 16,
  parameter logic [15:0] IMM_MASK  = 16'h000F,
  parameter int          HOLD_ADDR = 0,
  parameter int          LINE_ADDR = 1,
  parameter int          LW        = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_load_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               vsync,
  input  logic               hsync,
  output logic [NREG*DW-1:0] act_flat
);
  localparam int CW = $clog2(DW);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          load_rise;
  logic          ld_idle;
  logic [CW-1:0] bit_cnt;
  logic          addr_phase;
  logic          line_commit;
  logic          hold_bit;
  logic          sync_go;
  logic [DW-1:0] shadow_q [NREG];
  logic [DW-1:0] active_q [NREG];

  sreg_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .load_n(ser_load_n), .sclk(ser_clk),
    .sdata(ser_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_rise(load_rise), .load_idle(ld_idle), .bit_cnt(bit_cnt),
    .addr_phase(addr_phase)
  );

  assign hold_bit = active_q[HOLD_ADDR][0];
  assign sync_go  = line_commit & ~hold_bit;

  sreg_line_timer #(.LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
    .upd_line(active_q[LINE_ADDR][LW-1:0]), .commit(line_commit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] shadow_d, active_d;
    logic          take;

    if (IMM_MASK[i]) begin : g_imm
      assign take = load_rise;
    end else begin : g_sync
      assign take = sync_go;
    end

    always_comb begin
      shadow_d = shadow_q[i];
      active_d = active_q[i];
      if (wr_en && wr_addr == AW'(i)) shadow_d = wr_data & width_mask(i);
      if (take) active_d = shadow_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end else begin
        shadow_q[i] <= shadow_d;
        active_q[i] <= active_d;
      end
    end

    assign act_flat[i*DW +: DW] = active_q[i];
  end
endmodule

// File: rtl/sreg_write_port_chk.sv
module sreg_write_port_chk
  import sreg_pkg::*;
#(
  parameter int          NREG     = 16,
  parameter logic [15:0] IMM_MASK = 16'h000F,
  localparam int         CW       = $clog2(DW)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREG*DW-1:0] act_flat,
  input logic               load_rise,
  input logic               line_commit,
  input logic               hold_bit,
  input logic               ld_idle,
  input logic [CW-1:0]      bit_cnt,
  input logic               addr_phase,
  input logic               wr_en
);
  for (genvar i = 0; i < NREG; i++) begin : g_chk
    if (IMM_MASK[i]) begin : g_imm
      // R3
      imm_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_flat[i*DW +: DW]) |-> $past(load_rise));
    end else begin : g_sync
      // R8
      sync_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_flat[i*DW +: DW]) |-> $past(line_commit));
      // R10
      hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_commit && hold_bit) |=> $stable(act_flat[i*DW +: DW]));
    end
  end

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_idle |=> (bit_cnt == '0 && addr_phase));

  // R4
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(ld_idle));
endmodule

bind sreg_write_port sreg_write_port_chk #(.NREG(NREG), .IMM_MASK(IMM_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_flat(act_flat), .load_rise(load_rise),
  .line_commit(line_commit), .hold_bit(hold_bit), .ld_idle(ld_idle),
  .bit_cnt(bit_cnt), .addr_phase(addr_phase), .wr_en(wr_en)
);

// File: tb/tb_sreg_write_port.sv
module tb_sreg_write_port;
  localparam int NREG = 16;
  localparam int DW   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_load_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0;
  logic vsync = 1'b1, hsync = 1'b1;
  logic [NREG*DW-1:0] act_flat;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  sreg_write_port dut (
    .clk(clk), .rst_n(rst_n), .ser_load_n(ser_load_n), .ser_clk(ser_clk),
    .ser_data(ser_data), .vsync(vsync), .hsync(hsync), .act_flat(act_flat)
  );

  function automatic logic [DW-1:0] rd(int i);
    return act_flat[i*DW +: DW];
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic sbit(logic b);
    ser_data = b; cyc(2);
    ser_clk = 1'b1; cyc(2);
    ser_clk = 1'b0; cyc(2);
  endtask

  task automatic sbits(logic [DW-1:0] v, int n);
    for (int k = 0; k < n; k++) sbit(v[k]);
  endtask

  task automatic fbegin(logic [7:0] a);
    ser_load_n = 1'b0; cyc(2);
    sbits(DW'(a), 8);
  endtask

  task automatic fend();
    cyc(3); ser_load_n = 1'b1; cyc(6);
  endtask

  task automatic wr1(logic [7:0] a, logic [DW-1:0] d);
    fbegin(a); sbits(d, DW); fend();
  endtask

  task automatic vfall();
    vsync = 1'b0; cyc(3); vsync = 1'b1; cyc(3);
  endtask

  task automatic hfall();
    hsync = 1'b0; cyc(3); hsync = 1'b1; cyc(4);
  endtask

  task automatic t_reset();
    check("R1 reg0", rd(0), 24'h0);
    check("R1 reg15", rd(15), 24'h0);
  endtask

  task automatic t_imm();
    fbegin(8'h03); sbits(24'hA5C3F1, DW); cyc(6);
    check("R3 before strobe rise", rd(3), 24'h0);
    fend();
    check("R2 frame lsb-first", rd(3), 24'hA5C3F1);
  endtask

  task automatic t_width();
    wr1(8'h02, 24'hFFFFFF);
    check("R7 16-bit register", rd(2), 24'h00FFFF);
  endtask

  task automatic t_partial();
    for (int k = 0; k < 3; k++) begin
      ser_clk = 1'b1; cyc(2); ser_clk = 1'b0; cyc(2);
    end
    fbegin(8'h03); sbits(24'h3FF, 10); fend();
    check("R4 partial dropped", rd(3), 24'hA5C3F1);
    wr1(8'h03, 24'h000111);
    check("R11 counter cleared", rd(3), 24'h000111);
  endtask

  task automatic t_autoinc();
    fbegin(8'h02); sbits(24'h001111, DW); sbits(24'h222222, DW); fend();
    check("R5 first word", rd(2), 24'h001111);
    check("R5 next address", rd(3), 24'h222222);
  endtask

  task automatic t_wrap();
    fbegin(8'hFF); sbits(24'h777777, DW); sbits(24'h000040, DW);
    sbits(24'h000000, DW); fend();
    check("R6 wrap to reg0", rd(0), 24'h000040);
    check("R6 wrap to reg1", rd(1), 24'h000000);
    check("R6 no alias write", rd(2), 24'h001111);
  endtask

  task automatic t_sync();
    wr1(8'h05, 24'h000ABC);
    check("R8 no change on strobe", rd(5), 24'h0);
    hfall();
    check("R8 hsync alone", rd(5), 24'h0);
    vfall(); hfall();
    check("R8 committed", rd(5), 24'h000ABC);
  endtask

  task automatic t_line();
    wr1(8'h01, 24'h000002);
    wr1(8'h06, 24'h00BEEF);
    vfall();
    hfall(); check("R9 line 0", rd(6), 24'h0);
    hfall(); check("R9 line 1", rd(6), 24'h0);
    hfall(); check("R9 line 2", rd(6), 24'h00BEEF);
    wr1(8'h01, 24'h000000);
  endtask

  task automatic t_hold();
    wr1(8'h00, 24'h000001);
    wr1(8'h07, 24'h123456);
    vfall(); hfall();
    check("R10 held", rd(7), 24'h0);
    wr1(8'h00, 24'h000000);
    vfall(); hfall();
    check("R10 released", rd(7), 24'h123456);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(3);
    t_reset();
    t_imm();
    t_width();
    t_partial();
    t_autoinc();
    t_wrap();
    t_sync();
    t_line();
    t_hold();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule